// File: doc/BRIEF.md
# Privileged Status Register with Banked General Registers

This block holds a processor's 32-bit status word and the two banks of low general registers that the status word selects between. The status word carries a privilege mode bit, a bank-select bit, an interrupt-block bit, a floating-point disable bit, a 4-bit interrupt mask and four condition flags (M, Q, S, T). Software writes it through a write port. Exception entry, interrupt entry and a return-from-exception input also change it, by hardware.

On entry to an exception or an interrupt, the word as it stood is copied into a saved-status register. The live word is then forced into privileged mode, with the alternate bank selected and interrupts blocked. If a general exception other than a user-break arrives while interrupts are blocked, it is not taken. The block instead raises a reset-escalation request. Incoming interrupts are accepted against the block bit and the mask.

Eight general registers are read and written through a main port. The main port reaches the active bank, which is bank 1 only when both the mode and bank-select bits are 1. A separate control-transfer port reaches the other bank.

Top module: `psr_bank_ctrl`

## Requirements
- R1: After reset the status word reads 32'h7000_00F0: mode, bank and block bits set, mask 4'hF, all else 0. The saved-status word reads 0.
- R2: Bits 31, 27..16, 14..10 and 3..2 of the status word always read 0, whatever is written to them.
- R3: In privileged mode (bit 30 = 1), a software write loads bit 30 (mode), bit 29 (bank), bit 28 (block), bit 15 (FP disable), bits 9/8 (M/Q), bits 7..4 (mask), bit 1 (S) and bit 0 (T) at the next edge.
- R4: On a taken exception or an accepted interrupt, bits 30..28 are all 1 at the next edge and every other bit is unchanged.
- R5: While bit 28 is 1, `irq_take` stays 0 for every interrupt level.
- R6: If `exc_req` is high with `exc_ubrk` = 0 while bit 28 is 1, `rst_esc` is high in that same cycle, and the status and saved-status words do not change. A user-break exception (`exc_ubrk` = 1) in that state is taken normally.
- R7: Entry copies the pre-entry status word into `ssr_out`. `rte` loads the status word from `ssr_out` at the next edge.
- R8: `irq_take` is high in the same cycle exactly when `irq_req` is high, bit 28 is 0, `exc_req` is low and `irq_lvl` is strictly greater than bits 7..4.
- R9: In user mode (bit 30 = 0), software writes leave bits 30..28 unchanged but update the other writable bits, and writes on the control-transfer port are ignored.
- R10: The main GPR port reaches bank 1 when bits 30 and 29 are both 1 and bank 0 otherwise. The control-transfer port reaches the other bank. Reads are combinational and writes take effect at the edge.
- R11: In one cycle, exception entry beats interrupt entry, which beats `rte`, which beats a software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_wr_en | input | 1 | Software write strobe for the status word |
| sr_wr_data | input | 32 | Software write data |
| exc_req | input | 1 | General exception request |
| exc_ubrk | input | 1 | Qualifies the exception as a user-break |
| irq_req | input | 1 | Interrupt request |
| irq_lvl | input | LVL_W | Interrupt priority level |
| rte | input | 1 | Return from exception: restore from saved word |
| sr_out | output | 32 | Live status word |
| ssr_out | output | 32 | Saved status word |
| irq_take | output | 1 | Interrupt accepted this cycle |
| rst_esc | output | 1 | Reset-escalation request |
| gpr_we | input | 1 | Main port write enable |
| gpr_waddr | input | AW | Main port write index |
| gpr_wdata | input | GPR_W | Main port write data |
| gpr_raddr | input | AW | Main port read index |
| gpr_rdata | output | GPR_W | Main port read data |
| alt_we | input | 1 | Control-transfer port write enable |
| alt_waddr | input | AW | Control-transfer write index |
| alt_wdata | input | GPR_W | Control-transfer write data |
| alt_raddr | input | AW | Control-transfer read index |
| alt_rdata | output | GPR_W | Control-transfer read data |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is an exception and an interrupt. The bench raises `exc_req` and an interrupt whose level is above the mask in one cycle while the block bit is clear. It judges that `irq_take` stays low during that cycle, and that after the edge the saved word holds the pre-entry value once, from the exception.

The second pair is `rte` and a software write. The bench issues both together and judges that the status word equals the saved word, not the written data.

// File: rtl/psr_pkg.sv
package psr_pkg;
   localparam int SR_W     = 32;
   localparam int MD_BIT   = 30;
   localparam int RB_BIT   = 29;
   localparam int BL_BIT   = 28;
   localparam int MASK_LO  = 4;
   localparam int MASK_W   = 4;
   localparam logic [SR_W-1:0] SR_WMASK    = 32'h7000_83F3;
   localparam logic [SR_W-1:0] SR_PRIVBITS = 32'h7000_0000;
   localparam logic [SR_W-1:0] SR_RESET    = 32'h7000_00F0;

   typedef enum logic [1:0] {
      UPD_NONE  = 2'd0,
      UPD_ENTRY = 2'd1,
      UPD_RTE   = 2'd2,
      UPD_WRITE = 2'd3
   } sr_upd_e;
endpackage

// File: rtl/psr_int_gate.sv
module psr_int_gate #(
   parameter int LVL_W = 4
) (
   input  logic                       blk,
   input  logic [psr_pkg::MASK_W-1:0] imask,
   input  logic                       exc_req,
   input  logic                       exc_ubrk,
   input  logic                       irq_req,
   input  logic [LVL_W-1:0]           irq_lvl,
   output logic                       irq_take,
   output logic                       rst_esc,
   output logic                       entry
);
   logic lvl_above;
   logic exc_taken;

   assign lvl_above = irq_lvl > LVL_W'(imask);
   assign rst_esc   = exc_req & blk & ~exc_ubrk;
   assign exc_taken = exc_req & ~rst_esc;
   assign irq_take  = irq_req & ~blk & ~exc_req & lvl_above;
   assign entry     = exc_taken | irq_take;
endmodule

// File: rtl/psr_status_reg.sv
module psr_status_reg
   import psr_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            entry,
   input  logic            rte,
   input  logic            wr_en,
   input  logic [SR_W-1:0] wr_data,
   output logic [SR_W-1:0] sr,
   output logic [SR_W-1:0] ssr
);
   sr_upd_e         upd;
   logic [SR_W-1:0] wmask_now;

   assign wmask_now = sr[MD_BIT] ? SR_WMASK : (SR_WMASK & ~SR_PRIVBITS);

   always_comb begin
      if (entry)      upd = UPD_ENTRY;
      else if (rte)   upd = UPD_RTE;
      else if (wr_en) upd = UPD_WRITE;
      else            upd = UPD_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr  <= SR_RESET;
         ssr <= '0;
      end else begin
         case (upd)
            UPD_ENTRY: begin
               ssr <= sr;
               sr  <= sr | SR_PRIVBITS;
            end
            UPD_RTE:   sr <= ssr & SR_WMASK;
            UPD_WRITE: sr <= (sr & ~wmask_now) | (wr_data & wmask_now);
            default:   sr <= sr;
         endcase
      end
   end
endmodule

// File: rtl/psr_bank_file.sv
module psr_bank_file #(
   parameter int GPR_W      = 32,
   parameter int NUM_REGS   = 8,
   parameter bit RESET_GPRS = 1'b1,
   localparam int AW        = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_bank,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [GPR_W-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [GPR_W-1:0] rdata,
   input  logic             alt_we,
   input  logic [AW-1:0]    alt_waddr,
   input  logic [GPR_W-1:0] alt_wdata,
   input  logic [AW-1:0]    alt_raddr,
   output logic [GPR_W-1:0] alt_rdata
);
   logic [GPR_W-1:0] regs [2][NUM_REGS];

   for (genvar b = 0; b < 2; b++) begin : g_bank
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         logic             hit_main, hit_alt;
         logic [GPR_W-1:0] nxt;
         assign hit_main = we     && (act_bank == 1'(b)) && (waddr     == AW'(i));
         assign hit_alt  = alt_we && (act_bank != 1'(b)) && (alt_waddr == AW'(i));
         assign nxt      = hit_main ? wdata : alt_wdata;
         if (RESET_GPRS) begin : g_rst
            always_ff @(posedge clk) begin
               if (!rst_n)                  regs[b][i] <= '0;
               else if (hit_main | hit_alt) regs[b][i] <= nxt;
            end
         end else begin : g_norst
            always_ff @(posedge clk) begin
               if (hit_main | hit_alt) regs[b][i] <= nxt;
            end
         end
      end
   end

   assign rdata     = regs[act_bank][raddr];
   assign alt_rdata = regs[~act_bank][alt_raddr];
endmodule

// File: rtl/psr_bank_ctrl.sv
module psr_bank_ctrl
   import psr_pkg::*;
#(
   parameter int GPR_W      = 32,
   parameter int NUM_REGS   = 8,
   parameter int LVL_W      = 4,
   parameter bit RESET_GPRS = 1'b1,
   localparam int AW        = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sr_wr_en,
   input  logic [31:0]      sr_wr_data,
   input  logic             exc_req,
   input  logic             exc_ubrk,
   input  logic             irq_req,
   input  logic [LVL_W-1:0] irq_lvl,
   input  logic             rte,
   output logic [31:0]      sr_out,
   output logic [31:0]      ssr_out,
   output logic             irq_take,
   output logic             rst_esc,
   input  logic             gpr_we,
   input  logic [AW-1:0]    gpr_waddr,
   input  logic [GPR_W-1:0] gpr_wdata,
   input  logic [AW-1:0]    gpr_raddr,
   output logic [GPR_W-1:0] gpr_rdata,
   input  logic             alt_we,
   input  logic [AW-1:0]    alt_waddr,
   input  logic [GPR_W-1:0] alt_wdata,
   input  logic [AW-1:0]    alt_raddr,
   output logic [GPR_W-1:0] alt_rdata
);
   if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_chk_regs
      $error("NUM_REGS must be a power of two, at least 2");
   end
   if (LVL_W < MASK_W) begin : g_chk_lvl
      $error("LVL_W must be at least the mask width");
   end
   if (GPR_W < 1) begin : g_chk_w
      $error("GPR_W must be positive");
   end

   logic [SR_W-1:0] sr, ssr;
   logic            entry;
   logic            priv;
   logic            act_bank;

   psr_int_gate #(.LVL_W(LVL_W)) u_gate (
      .blk      (sr[BL_BIT]),
      .imask    (sr[MASK_LO +: MASK_W]),
      .exc_req  (exc_req),
      .exc_ubrk (exc_ubrk),
      .irq_req  (irq_req),
      .irq_lvl  (irq_lvl),
      .irq_take (irq_take),
      .rst_esc  (rst_esc),
      .entry    (entry)
   );

   psr_status_reg u_sr (
      .clk     (clk),
      .rst_n   (rst_n),
      .entry   (entry),
      .rte     (rte),
      .wr_en   (sr_wr_en),
      .wr_data (sr_wr_data),
      .sr      (sr),
      .ssr     (ssr)
   );

   assign priv     = sr[MD_BIT];
   assign act_bank = priv & sr[RB_BIT];

   psr_bank_file #(
      .GPR_W      (GPR_W),
      .NUM_REGS   (NUM_REGS),
      .RESET_GPRS (RESET_GPRS)
   ) u_banks (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_bank  (act_bank),
      .we        (gpr_we),
      .waddr     (gpr_waddr),
      .wdata     (gpr_wdata),
      .raddr     (gpr_raddr),
      .rdata     (gpr_rdata),
      .alt_we    (alt_we & priv),
      .alt_waddr (alt_waddr),
      .alt_wdata (alt_wdata),
      .alt_raddr (alt_raddr),
      .alt_rdata (alt_rdata)
   );

   assign sr_out  = sr;
   assign ssr_out = ssr;
endmodule

// File: rtl/psr_bank_ctrl_chk.sv
module psr_bank_ctrl_chk #(
   parameter int LVL_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             exc_req,
   input logic             exc_ubrk,
   input logic             irq_req,
   input logic [LVL_W-1:0] irq_lvl,
   input logic             rte,
   input logic [31:0]      sr_out,
   input logic [31:0]      ssr_out,
   input logic             irq_take,
   input logic             rst_esc
);
   AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_out & ~32'h7000_83F3) == 32'h0); // R2

   AST_ENTRY_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
      ((exc_req && !rst_esc) || irq_take) |=> sr_out[30:28] == 3'b111); // R4

   AST_BLOCK_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
      sr_out[28] |-> !irq_take); // R5

   AST_ESC_COND: assert property (@(posedge clk) disable iff (!rst_n)
      rst_esc |-> (exc_req && !exc_ubrk && sr_out[28])); // R6

   AST_ESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_esc && !irq_take) |=> ($stable(sr_out) && $stable(ssr_out))); // R6

   AST_ENTRY_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
      ((exc_req && !rst_esc) || irq_take) |=> ssr_out == $past(sr_out)); // R7

   AST_IRQ_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |-> (irq_req && !exc_req && irq_lvl > LVL_W'(sr_out[7:4]))); // R8

   AST_USER_PRIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!sr_out[30] && !exc_req && !irq_take && !rte) |=> sr_out[30:28] == $past(sr_out[30:28])); // R9
endmodule

bind psr_bank_ctrl psr_bank_ctrl_chk #(.LVL_W(LVL_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .exc_req  (exc_req),
   .exc_ubrk (exc_ubrk),
   .irq_req  (irq_req),
   .irq_lvl  (irq_lvl),
   .rte      (rte),
   .sr_out   (sr_out),
   .ssr_out  (ssr_out),
   .irq_take (irq_take),
   .rst_esc  (rst_esc)
);

// File: tb/psr_bank_ctrl_bench.sv
`timescale 1ns/1ps
module psr_bank_ctrl_bench;
   localparam int GPR_W = 32;
   localparam int NREG  = 8;
   localparam int LVL_W = 4;
   localparam int AW    = $clog2(NREG);

   logic clk = 1'b0;
   logic rst_n;
   logic sr_wr_en;
   logic [31:0] sr_wr_data;
   logic exc_req, exc_ubrk, irq_req, rte;
   logic [LVL_W-1:0] irq_lvl;
   logic [31:0] sr_out, ssr_out;
   logic irq_take, rst_esc;
   logic gpr_we, alt_we;
   logic [AW-1:0] gpr_waddr, gpr_raddr, alt_waddr, alt_raddr;
   logic [GPR_W-1:0] gpr_wdata, gpr_rdata, alt_wdata, alt_rdata;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   psr_bank_ctrl u_psr_bank_ctrl (
      .clk(clk), .rst_n(rst_n), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
      .exc_req(exc_req), .exc_ubrk(exc_ubrk), .irq_req(irq_req), .irq_lvl(irq_lvl),
      .rte(rte), .sr_out(sr_out), .ssr_out(ssr_out), .irq_take(irq_take),
      .rst_esc(rst_esc), .gpr_we(gpr_we), .gpr_waddr(gpr_waddr),
      .gpr_wdata(gpr_wdata), .gpr_raddr(gpr_raddr), .gpr_rdata(gpr_rdata),
      .alt_we(alt_we), .alt_waddr(alt_waddr), .alt_wdata(alt_wdata),
      .alt_raddr(alt_raddr), .alt_rdata(alt_rdata)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      sr_wr_en = 0; exc_req = 0; exc_ubrk = 0; irq_req = 0; rte = 0;
      gpr_we = 0; alt_we = 0;
   endtask

   task automatic sw_write(input logic [31:0] d);
      sr_wr_en = 1; sr_wr_data = d;
      step();
      sr_wr_en = 0;
   endtask

   task automatic t_reset();
      chk("R1 sr reset", sr_out, 32'h7000_00F0);
      chk("R1 ssr reset", ssr_out, 32'h0);
   endtask

   task automatic t_priv_write();
      sw_write(32'hFFFF_FFFF);
      chk("R3 R2 write all ones", sr_out, 32'h7000_83F3);
      sw_write(32'h4000_0035);
      chk("R3 R2 partial write", sr_out, 32'h4000_0031);
   endtask

   task automatic t_banks_priv();
      gpr_we = 1; gpr_waddr = 3; gpr_wdata = 32'hA0;
      alt_we = 1; alt_waddr = 3; alt_wdata = 32'hB1;
      step();
      gpr_we = 0; alt_we = 0;
      gpr_raddr = 3; alt_raddr = 3; #1;
      chk("R10 main bank0", gpr_rdata, 32'hA0);
      chk("R10 alt bank1", alt_rdata, 32'hB1);
      sw_write(32'h6000_0030);
      #1;
      chk("R10 main bank1", gpr_rdata, 32'hB1);
      chk("R10 alt bank0", alt_rdata, 32'hA0);
   endtask

   task automatic t_irq();
      irq_req = 1; irq_lvl = 4'd3; #1;
      chk("R8 level equal mask", {31'b0, irq_take}, 32'd0);
      irq_lvl = 4'd4; #1;
      chk("R8 level above mask", {31'b0, irq_take}, 32'd1);
      step();
      irq_req = 0;
      chk("R4 irq entry sr", sr_out, 32'h7000_0030);
      chk("R7 irq entry ssr", ssr_out, 32'h6000_0030);
      irq_req = 1; irq_lvl = 4'hF; #1;
      chk("R5 blocked max level", {31'b0, irq_take}, 32'd0);
      step();
      irq_req = 0;
      chk("R5 blocked no entry", sr_out, 32'h7000_0030);
   endtask

   task automatic t_rte();
      rte = 1; step(); rte = 0;
      chk("R7 rte restore", sr_out, 32'h6000_0030);
      sw_write(32'h4000_0000);
      chk("R3 clear bank", sr_out, 32'h4000_0000);
      rte = 1; sr_wr_en = 1; sr_wr_data = 32'h4000_83F3;
      step();
      rte = 0; sr_wr_en = 0;
      chk("R11 rte beats write", sr_out, 32'h6000_0030);
   endtask

   task automatic t_user();
      sw_write(32'h0000_0030);
      chk("R3 drop to user", sr_out, 32'h0000_0030);
      sw_write(32'h7000_0045);
      chk("R9 user write keeps priv bits", sr_out, 32'h0000_0041);
      alt_we = 1; alt_waddr = 3; alt_wdata = 32'hDEAD; step(); alt_we = 0;
      alt_raddr = 3; #1;
      chk("R9 alt write ignored", alt_rdata, 32'hB1);
   endtask

   task automatic t_exc_vs_irq();
      exc_req = 1; irq_req = 1; irq_lvl = 4'd9; #1;
      chk("R11 R8 exc suppresses irq", {31'b0, irq_take}, 32'd0);
      chk("R6 no esc when unblocked", {31'b0, rst_esc}, 32'd0);
      step();
      exc_req = 0; irq_req = 0;
      chk("R4 exc entry sr", sr_out, 32'h7000_0041);
      chk("R7 exc entry ssr", ssr_out, 32'h0000_0041);
   endtask

   task automatic t_escalate();
      exc_req = 1; exc_ubrk = 0; #1;
      chk("R6 escalation", {31'b0, rst_esc}, 32'd1);
      step();
      exc_req = 0;
      chk("R6 sr held", sr_out, 32'h7000_0041);
      chk("R6 ssr held", ssr_out, 32'h0000_0041);
      exc_req = 1; exc_ubrk = 1; #1;
      chk("R6 user break no esc", {31'b0, rst_esc}, 32'd0);
      step();
      exc_req = 0; exc_ubrk = 0;
      chk("R6 user break taken", ssr_out, 32'h7000_0041);
   endtask

   task automatic t_user_bank_gate();
      sw_write(32'h2000_00F0);
      chk("R3 user with bank bit", sr_out, 32'h2000_00F0);
      gpr_raddr = 3; alt_raddr = 3; #1;
      chk("R10 user maps bank0", gpr_rdata, 32'hA0);
      chk("R10 user alt bank1", alt_rdata, 32'hB1);
   endtask

   initial begin
      idle();
      sr_wr_data = 0; irq_lvl = 0; gpr_waddr = 0; gpr_wdata = 0; gpr_raddr = 0;
      alt_waddr = 0; alt_wdata = 0; alt_raddr = 0;
      rst_n = 0;
      repeat (3) step();
      rst_n = 1;
      step();
      t_reset();
      t_priv_write();
      t_banks_priv();
      t_irq();
      t_rte();
      t_user();
      t_exc_vs_irq();
      t_escalate();
      t_user_bank_gate();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule